// File: doc/BRIEF.md
# Management-Memory Base Relocation Register

This block keeps the base address of the protected management memory window and derives the addresses that the mode-entry sequencer needs from it. These are the handler entry vector, the lower and upper bounds of the state-save window, and the address of the save slot that records the base. After reset the base holds a fixed default. When the sequencer pulses the entry strobe, the block emits a one-cycle write of the current base, aimed at its save slot. When the sequencer pulses the resume strobe, it also presents the slot contents, which the handler may have rewritten.

At resume the block adopts a new base only if the slot value sits on a 32 KB boundary. The new base then governs the next entry. If the value is misaligned, the block keeps its stored base and raises a shutdown flag. That flag stays set until reset, and while it is set both strobes are ignored.

The slot value is a single-cycle valid (the resume strobe) with no back-pressure: the block is always ready and consumes the value on the cycle the strobe is high. The save-slot write leaves as a one-cycle valid pulse, and the sequencer must take it on that cycle. The entry and resume strobes are single-cycle pulses and never high together.

Top module: `smram_reloc`

## Requirements
- R1: After reset, the base output is 0x0003_0000, shutdown is 0, and the slot-write valid is 0.
- R2: The entry vector always equals base + 0x8000, computed modulo 2^32.
- R3: The save window lower bound is base + 0x8000 and its upper bound is base + 0xFFFF, both modulo 2^32. With the default base this gives 0x38000 and 0x3FFFF.
- R4: An entry strobe accepted while not in shutdown raises the slot-write valid in the next cycle for exactly one cycle. The write address is base + 0xFEF8 (save-window offset 0x7EF8) and the data is the base held when the strobe was sampled.
- R5: A resume strobe whose slot value has bits 14:0 all zero replaces the base with that value from the next cycle on.
- R6: A resume strobe whose slot value has any of bits 14:0 set raises shutdown in the next cycle and leaves the base unchanged.
- R7: Once set, shutdown stays at 1 until reset. While it is 1, resume strobes do not change the base and entry strobes produce no slot write.
- R8: The code-segment selector output is 0x3000 at all times, including after the base has been relocated.
- R9: An entry strobe in the cycle right after an accepted resume uses the new base for its vector, bounds, slot address and slot data.
- R10: Cycles without an accepted resume leave the base unchanged, including entry cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| entry_stb | input | 1 | One-cycle pulse: management-mode entry |
| resume_stb | input | 1 | One-cycle pulse: resume, slot value valid |
| resume_slot | input | 32 | Base slot contents read at resume |
| cur_base | output | 32 | Current stored base |
| entry_vec | output | 32 | Handler entry address |
| save_lo | output | 32 | Lowest save-window address |
| save_hi | output | 32 | Highest save-window address |
| slot_wr_vld | output | 1 | One-cycle valid of the base save write |
| slot_wr_addr | output | 32 | Address of the base save slot |
| slot_wr_data | output | 32 | Base value to be saved |
| cs_sel | output | 16 | Code-segment selector reported in the mode |
| shutdown | output | 1 | Sticky misaligned-base shutdown flag |

## Verification
Two functions can meet in a single cycle: a base update from an accepted resume, and the capture of the base for the save-slot write by an entry strobe in the following cycle. Both act on the same register at consecutive edges. The bench provokes this with back-to-back resume-then-entry pulses, in directed form and in random order. It judges the pair by requiring that the slot data and address come from the new base and not the old one. A misaligned resume followed at once by an entry is also driven, and the bench requires that no slot write appears.

// File: rtl/smram_pkg.sv
package smram_pkg;
  parameter int unsigned SMR_AW = 32;
  parameter int unsigned SMR_ALIGN = 15;

  typedef struct packed {
    logic              vld;
    logic [SMR_AW-1:0] addr;
    logic [SMR_AW-1:0] data;
  } slot_wr_t;
endpackage

// File: rtl/smram_align_chk.sv
module smram_align_chk #(
  parameter int unsigned AW        = 32,
  parameter int unsigned ALIGN_BITS = 15
) (
  input  logic [AW-1:0] value,
  output logic          aligned
);
  localparam logic [AW-1:0] LOW_MASK = AW'((64'd1 << ALIGN_BITS) - 64'd1);

  always_comb begin
    aligned = ((value & LOW_MASK) == '0);
  end
endmodule

// File: rtl/smram_base_reg.sv
module smram_base_reg #(
  parameter int unsigned    AW         = 32,
  parameter int unsigned    ALIGN_BITS = 15,
  parameter logic [AW-1:0]  RST_BASE   = 32'h0003_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          resume_stb,
  input  logic [AW-1:0] resume_slot,
  output logic [AW-1:0] base_q,
  output logic          shut_q
);
  logic aligned;

  smram_align_chk #(.AW(AW), .ALIGN_BITS(ALIGN_BITS)) align_i (
    .value   (resume_slot),
    .aligned (aligned)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= RST_BASE;
      shut_q <= 1'b0;
    end else if (resume_stb && !shut_q) begin
      if (aligned) begin
        base_q <= resume_slot;
      end else begin
        shut_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/smram_addr_map.sv
module smram_addr_map #(
  parameter int unsigned             AW         = 32,
  parameter int unsigned             ALIGN_BITS = 15,
  parameter logic [ALIGN_BITS-1:0]   SLOT_OFF   = 15'h7EF8
) (
  input  logic [AW-1:0] base,
  output logic [AW-1:0] vec,
  output logic [AW-1:0] lo,
  output logic [AW-1:0] hi,
  output logic [AW-1:0] slot
);
  localparam int unsigned UW = AW - ALIGN_BITS;

  logic [UW-1:0]         upper_nxt;
  logic [ALIGN_BITS-1:0] base_low;

  // The stored base is always aligned, so only the upper field needs an adder.
  always_comb begin
    upper_nxt = base[AW-1:ALIGN_BITS] + UW'(1);
    base_low  = base[ALIGN_BITS-1:0];
    vec  = {upper_nxt, base_low};
    lo   = {upper_nxt, base_low};
    hi   = {upper_nxt, {ALIGN_BITS{1'b1}}};
    slot = {upper_nxt, SLOT_OFF};
  end
endmodule

// File: rtl/smram_entry_cap.sv
module smram_entry_cap
  import smram_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          entry_stb,
  input  logic          shut,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] slot_addr,
  output logic          wr_vld,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] wr_data
);
  logic take;

  always_comb begin
    take = entry_stb && !shut;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_vld  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_vld <= take;
      if (take) begin
        wr_addr <= slot_addr;
        wr_data <= base;
      end
    end
  end
endmodule

// File: rtl/smram_reloc.sv
module smram_reloc
  import smram_pkg::*;
#(
  parameter int unsigned AW         = SMR_AW,
  parameter int unsigned ALIGN_BITS = SMR_ALIGN,
  parameter logic [AW-1:0] RST_BASE = 32'h0003_0000,
  parameter logic [15:0] CS_SEL_VAL = 16'h3000,
  parameter logic [ALIGN_BITS-1:0] SLOT_OFF = 15'h7EF8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          entry_stb,
  input  logic          resume_stb,
  input  logic [31:0]   resume_slot,
  output logic [31:0]   cur_base,
  output logic [31:0]   entry_vec,
  output logic [31:0]   save_lo,
  output logic [31:0]   save_hi,
  output logic          slot_wr_vld,
  output logic [31:0]   slot_wr_addr,
  output logic [31:0]   slot_wr_data,
  output logic [15:0]   cs_sel,
  output logic          shutdown
);
  logic [AW-1:0] base_q;
  logic          shut_q;
  logic [AW-1:0] slot_addr;
  slot_wr_t      wr;

  smram_base_reg #(.AW(AW), .ALIGN_BITS(ALIGN_BITS), .RST_BASE(RST_BASE)) base_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .resume_stb  (resume_stb),
    .resume_slot (resume_slot),
    .base_q      (base_q),
    .shut_q      (shut_q)
  );

  smram_addr_map #(.AW(AW), .ALIGN_BITS(ALIGN_BITS), .SLOT_OFF(SLOT_OFF)) map_i (
    .base (base_q),
    .vec  (entry_vec),
    .lo   (save_lo),
    .hi   (save_hi),
    .slot (slot_addr)
  );

  smram_entry_cap #(.AW(AW)) cap_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .entry_stb (entry_stb),
    .shut      (shut_q),
    .base      (base_q),
    .slot_addr (slot_addr),
    .wr_vld    (wr.vld),
    .wr_addr   (wr.addr),
    .wr_data   (wr.data)
  );

  always_comb begin
    cur_base     = base_q;
    shutdown     = shut_q;
    slot_wr_vld  = wr.vld;
    slot_wr_addr = wr.addr;
    slot_wr_data = wr.data;
    cs_sel       = CS_SEL_VAL;
  end
endmodule

// File: rtl/smram_reloc_chk.sv
module smram_reloc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        entry_stb,
  input logic        resume_stb,
  input logic [31:0] resume_slot,
  input logic [31:0] cur_base,
  input logic [31:0] entry_vec,
  input logic [31:0] save_lo,
  input logic [31:0] save_hi,
  input logic        slot_wr_vld,
  input logic [31:0] slot_wr_addr,
  input logic [31:0] slot_wr_data,
  input logic        shutdown
);
  p_vec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    entry_vec == cur_base + 32'h8000);

  p_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (save_hi - save_lo == 32'h7FFF) && (save_lo == entry_vec));

  p_slot_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_stb && !shutdown) |=> (slot_wr_vld && slot_wr_data == $past(cur_base)
                                  && slot_wr_addr == $past(cur_base) + 32'hFEF8));

  p_slot_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    slot_wr_vld |-> $past(entry_stb));

  p_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_stb && !shutdown && resume_slot[14:0] == 15'h0) |=> cur_base == $past(resume_slot));

  p_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_stb && resume_slot[14:0] != 15'h0) |=> (shutdown && $stable(cur_base)));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> (shutdown && $stable(cur_base) && !slot_wr_vld));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !resume_stb |=> $stable(cur_base));
endmodule

bind smram_reloc smram_reloc_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .entry_stb    (entry_stb),
  .resume_stb   (resume_stb),
  .resume_slot  (resume_slot),
  .cur_base     (cur_base),
  .entry_vec    (entry_vec),
  .save_lo      (save_lo),
  .save_hi      (save_hi),
  .slot_wr_vld  (slot_wr_vld),
  .slot_wr_addr (slot_wr_addr),
  .slot_wr_data (slot_wr_data),
  .shutdown     (shutdown)
);

// File: tb/smram_reloc_tb.sv
module smram_reloc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        entry_stb = 1'b0;
  logic        resume_stb = 1'b0;
  logic [31:0] resume_slot = '0;
  logic [31:0] cur_base, entry_vec, save_lo, save_hi, slot_wr_addr, slot_wr_data;
  logic        slot_wr_vld, shutdown;
  logic [15:0] cs_sel;

  int checks = 0;
  int fails = 0;
  logic [31:0] m_base;
  logic        m_shut;
  logic        m_wr;
  logic [31:0] m_wr_data;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  smram_reloc dut_i (
    .clk(clk), .rst_n(rst_n), .entry_stb(entry_stb), .resume_stb(resume_stb),
    .resume_slot(resume_slot), .cur_base(cur_base), .entry_vec(entry_vec),
    .save_lo(save_lo), .save_hi(save_hi), .slot_wr_vld(slot_wr_vld),
    .slot_wr_addr(slot_wr_addr), .slot_wr_data(slot_wr_data), .cs_sel(cs_sel),
    .shutdown(shutdown)
  );

  function automatic logic [31:0] f_vec(input logic [31:0] b);
    return b + 32'h0000_8000;
  endfunction
  function automatic logic [31:0] f_hi(input logic [31:0] b);
    return b + 32'h0000_FFFF;
  endfunction
  function automatic logic [31:0] f_slot(input logic [31:0] b);
    return b + 32'h0000_FEF8;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R5/R6/R10 base", cur_base, m_base);
    chk("R2 vector", entry_vec, f_vec(m_base));
    chk("R3 save_lo", save_lo, f_vec(m_base));
    chk("R3 save_hi", save_hi, f_hi(m_base));
    chk("R6/R7 shutdown", {31'b0, shutdown}, {31'b0, m_shut});
    chk("R8 cs_sel", {16'b0, cs_sel}, 32'h0000_3000);
    chk("R4/R7 slot_wr_vld", {31'b0, slot_wr_vld}, {31'b0, m_wr});
    if (m_wr) begin
      chk("R4/R9 slot data", slot_wr_data, m_wr_data);
      chk("R4/R9 slot addr", slot_wr_addr, f_slot(m_wr_data));
    end
  endtask

  // Drive inputs at a falling edge, let one rising edge pass, check at the next falling edge.
  task automatic cyc(input logic e, input logic r, input logic [31:0] slot);
    logic [31:0] b0;
    logic        s0;
    entry_stb   = e;
    resume_stb  = r;
    resume_slot = slot;
    b0 = m_base;
    s0 = m_shut;
    @(posedge clk);
    m_wr      = e && !s0;
    m_wr_data = b0;
    if (r && !s0) begin
      if (slot[14:0] == 15'h0) m_base = slot;
      else m_shut = 1'b1;
    end
    @(negedge clk);
    check_all();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    entry_stb = 1'b0;
    resume_stb = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_base = 32'h0003_0000;
    m_shut = 1'b0;
    m_wr = 1'b0;
    m_wr_data = '0;
    check_all(); // R1
  endtask

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'd1729);
    m_base = 32'h0003_0000; m_shut = 1'b0; m_wr = 1'b0; m_wr_data = '0;
    @(negedge clk);
    do_reset();
    chk("R1 default base", cur_base, 32'h0003_0000);
    chk("R3 default lo", save_lo, 32'h0003_8000);
    chk("R3 default hi", save_hi, 32'h0003_FFFF);
    // R4 entry with default base
    cyc(1'b1, 1'b0, 32'h0);
    chk("R4 default slot addr", slot_wr_addr, 32'h0003_FEF8);
    cyc(1'b0, 1'b0, 32'h0);
    // R9 resume then entry in the next cycle
    cyc(1'b0, 1'b1, 32'h0010_0000);
    cyc(1'b1, 1'b0, 32'h0);
    chk("R9 new base data", slot_wr_data, 32'h0010_0000);
    cyc(1'b0, 1'b0, 32'h0);
    // R2/R3 wraparound at the top of the address space
    cyc(1'b0, 1'b1, 32'hFFFF_8000);
    chk("R2 wrap vec", entry_vec, 32'h0000_0000);
    chk("R3 wrap hi", save_hi, 32'h0000_7FFF);
    // R6 smallest misaligned offset, followed at once by entry (R7 no write)
    cyc(1'b0, 1'b1, 32'h0010_0001);
    cyc(1'b1, 1'b0, 32'h0);
    cyc(1'b0, 1'b1, 32'h0020_0000); // R7 aligned resume ignored
    cyc(1'b0, 1'b0, 32'h0);
    do_reset();
    // R6 misaligned at bit 14
    cyc(1'b0, 1'b1, 32'h0004_4000);
    cyc(1'b0, 1'b0, 32'h0);
    do_reset();
    // Random phase
    for (int i = 0; i < 600; i++) begin
      int op;
      logic [31:0] v;
      op = int'($urandom_range(0, 15));
      v = $urandom();
      if (op < 6) cyc(1'b0, 1'b0, v);
      else if (op < 10) cyc(1'b1, 1'b0, v);
      else if (op < 15) cyc(1'b0, 1'b1, v & 32'hFFFF_8000);
      else cyc(1'b0, 1'b1, v | 32'h0000_0100);
      if (m_shut && ($urandom_range(0, 7) == 0)) do_reset();
    end
    cyc(1'b0, 1'b0, 32'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule